// File: doc/BRIEF.md
# DMA Channel Interrupt Status Aggregator

This block gathers the completion events of sixteen DMA channels into one 32-bit sticky pending register and drives a single interrupt line. The channels fall into two groups of eight, normal and dedicated. Each channel reports two events: reaching the halfway point of a transfer, and finishing it. A one-cycle pulse on an event input sets its pending bit. The bit stays set until software clears it by writing a one to that position.

A 32-bit enable register masks the pending bits. The interrupt line is high whenever an enabled bit is pending. Software normally enables only the end-of-transfer bit of a channel it has claimed. When it releases the channel, it clears that enable bit and that pending bit.

To save the handler a scan of the register, the block also reports the lowest-numbered pending end-of-transfer event among the enabled ones. It gives this as a group flag and a channel index within the group.

Top module: `dma_irq_aggregator`

## Requirements
- R1: Channel n (0..7) of the normal group sets bit 2n on its half-transfer event and bit 2n+1 on its end-of-transfer event. Channel n of the dedicated group sets bits 16+2n and 17+2n in the same way.
- R2: An event pulse sampled at a rising edge sets its pending bit from that edge on, whatever the enable value. The bit stays set until it is cleared.
- R3: A write with reg_addr=0 clears every pending bit whose reg_wdata bit is one and leaves the others unchanged. Writing all ones clears the whole register. Writing back a value just read clears exactly those bits.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit is set after that edge.
- R5: A write with reg_addr=1 loads reg_wdata into the enable register. The enable register resets to all zero.
- R6: While rst_n is low at a rising edge, the pending register clears. After reset, irq_out and eot_valid are low.
- R7: irq_out is high exactly when some bit is set in both the pending and the enable register. It follows register updates in the same cycle.
- R8: eot_valid is high when any end-of-transfer bit (odd position) is both pending and enabled. eot_dedicated and eot_chan then name the lowest such bit b: eot_dedicated = 1 for b >= 16, and eot_chan = (b/2) mod 8. Half-transfer bits never drive these outputs.
- R9: reg_rdata shows the pending register when reg_addr=0 and the enable register when reg_addr=1, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| norm_half_ev | input | 8 | Half-transfer pulses, normal channels |
| norm_end_ev | input | 8 | End-of-transfer pulses, normal channels |
| ded_half_ev | input | 8 | Half-transfer pulses, dedicated channels |
| ded_end_ev | input | 8 | End-of-transfer pulses, dedicated channels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects pending, 1 selects enable |
| reg_wdata | input | 32 | Write data (clear mask for pending) |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_out | output | 1 | Combined interrupt |
| eot_valid | output | 1 | An enabled end-of-transfer bit is pending |
| eot_dedicated | output | 1 | Group of the reported channel (1 = dedicated) |
| eot_chan | output | 3 | Channel index within the group |

## Verification
The assertions assume that the event inputs are single-cycle pulses and that they are low while reset is held. Only under that assumption do the sticky-set and hold properties describe real behaviour. The stimulus raises each event for exactly one clock and keeps every event low during reset. It changes inputs only a short time after a rising edge, so each pulse and each write is sampled at exactly one edge, and a collision between a pulse and a clear is forced by driving both in the same cycle.

// File: rtl/dma_irq_pkg.sv
// Shared sizing for the DMA interrupt status aggregator.
// Assumes each channel owns two adjacent status bits (half, then end).
package dma_irq_pkg;
    parameter int CH_PER_GRP = 8;
    parameter int N_GRP      = 2;
    localparam int NUM_CH    = CH_PER_GRP * N_GRP;
    localparam int STAT_W    = 2 * NUM_CH;
    localparam int CH_IDX_W  = $clog2(NUM_CH);
    localparam int GRP_CH_W  = $clog2(CH_PER_GRP);
endpackage

// File: rtl/irq_pend_bank.sv
// Sticky pending register bank with write-one-to-clear.
// Assumes set pulses last one cycle; set wins over a simultaneous clear.
module irq_pend_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] pend
);
    logic [W-1:0] clr_eff;

    // Purpose: qualify the clear mask with the write strobe.
    always_comb begin
        clr_eff = clr_en ? clr_mask : '0;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // Purpose: hold one sticky bit; set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend[i] <= 1'b0;
                else if (set_vec[i])
                    pend[i] <= 1'b1;
                else if (clr_eff[i])
                    pend[i] <= 1'b0;
            end
        end
    endgenerate

    // R2: every pulsed bit is pending after the edge
    a_r2_set_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    // R3: cleared bits without a simultaneous event are low afterwards
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((pend & $past(clr_mask & ~set_vec)) == '0));

    // R4: collision keeps the bit set
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && ((clr_mask & set_vec) != '0))
        |=> ((pend & $past(clr_mask & set_vec)) == $past(clr_mask & set_vec)));

    // R2: without events or writes the register holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && set_vec == '0) |=> $stable(pend));
endmodule

// File: rtl/irq_enable_reg.sv
// Interrupt enable mask register, loaded whole on a write.
// Assumes software writes the full word; resets to all masked.
module irq_enable_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en
);
    // Purpose: store the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en <= '0;
        else if (wr_en)
            en <= wdata;
    end

    // R5: a write is visible on the next cycle
    a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en == $past(wdata)));

    // R5: without a write the mask holds
    a_r5_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en));
endmodule

// File: rtl/irq_lowest_finder.sv
// Priority encoder: index of the lowest set bit in a request vector.
// Assumes nothing about the vector; index is zero when none is set.
module irq_lowest_finder #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Purpose: scan from the top so the lowest set bit is the last one kept.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    // R8: the reported bit is set and no lower bit is set
    always_comb begin
        if (found) begin
            a_r8_idx_set: assert (req[idx]);
            a_r8_idx_lowest: assert ((req & ((N'(1) << idx) - N'(1))) == '0);
        end else begin
            a_r8_none: assert (req == '0);
        end
    end
endmodule

// File: rtl/dma_irq_aggregator.sv
// Top: maps channel events into the interleaved pending word, applies the
// enable mask, drives the combined interrupt and the lowest end-event report.
// Assumes event inputs are single-cycle pulses.
module dma_irq_aggregator
    import dma_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CH_PER_GRP-1:0] norm_half_ev,
    input  logic [CH_PER_GRP-1:0] norm_end_ev,
    input  logic [CH_PER_GRP-1:0] ded_half_ev,
    input  logic [CH_PER_GRP-1:0] ded_end_ev,
    input  logic                  reg_wr,
    input  logic                  reg_addr,
    input  logic [STAT_W-1:0]     reg_wdata,
    output logic [STAT_W-1:0]     reg_rdata,
    output logic                  irq_out,
    output logic                  eot_valid,
    output logic                  eot_dedicated,
    output logic [GRP_CH_W-1:0]   eot_chan
);
    logic [NUM_CH-1:0]   half_all;
    logic [NUM_CH-1:0]   end_all;
    logic [STAT_W-1:0]   set_vec;
    logic [STAT_W-1:0]   pend;
    logic [STAT_W-1:0]   en;
    logic [STAT_W-1:0]   active;
    logic [NUM_CH-1:0]   end_active;
    logic [CH_IDX_W-1:0] low_ch;

    assign half_all = {ded_half_ev, norm_half_ev};
    assign end_all  = {ded_end_ev, norm_end_ev};

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_map
            // Channel c owns bits 2c (half) and 2c+1 (end).
            assign set_vec[2*c]     = half_all[c];
            assign set_vec[2*c + 1] = end_all[c];
            assign end_active[c]    = active[2*c + 1];
        end
    endgenerate

    irq_pend_bank #(.W(STAT_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_en   (reg_wr && !reg_addr),
        .clr_mask (reg_wdata),
        .pend     (pend)
    );

    irq_enable_reg #(.W(STAT_W)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr && reg_addr),
        .wdata (reg_wdata),
        .en    (en)
    );

    irq_lowest_finder #(.N(NUM_CH), .IDX_W(CH_IDX_W)) u_find (
        .req   (end_active),
        .found (eot_valid),
        .idx   (low_ch)
    );

    // Purpose: mask pending bits, form the interrupt and the read mux.
    always_comb begin
        active    = pend & en;
        irq_out   = |active;
        reg_rdata = reg_addr ? en : pend;
    end

    assign eot_dedicated = low_ch[CH_IDX_W-1];
    assign eot_chan      = low_ch[GRP_CH_W-1:0];

    // R8: a valid report implies the interrupt is raised
    a_r8_valid_irq: assert property (@(posedge clk) disable iff (!rst_n)
        eot_valid |-> irq_out);

    // R6: the cycle after reset nothing is pending
    a_r6_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && !eot_valid));
endmodule

// File: tb/tb_dma_irq_aggregator.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_dma_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  norm_half_ev = '0, norm_end_ev = '0, ded_half_ev = '0, ded_end_ev = '0;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out, eot_valid, eot_dedicated;
    logic [2:0]  eot_chan;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dma_irq_aggregator dut (
        .clk(clk), .rst_n(rst_n),
        .norm_half_ev(norm_half_ev), .norm_end_ev(norm_end_ev),
        .ded_half_ev(ded_half_ev), .ded_end_ev(ded_end_ev),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .eot_valid(eot_valid),
        .eot_dedicated(eot_dedicated), .eot_chan(eot_chan)
    );

    // Advance one edge; inputs change 1 ns after it, checks sample there too.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; reg_addr = 1'b0;
    endtask

    // grp: 0 normal, 1 dedicated; is_end: 0 half, 1 end
    task automatic pulse(input logic grp, input int ch, input logic is_end);
        if (!grp && !is_end) norm_half_ev[ch] = 1'b1;
        if (!grp &&  is_end) norm_end_ev[ch]  = 1'b1;
        if ( grp && !is_end) ded_half_ev[ch]  = 1'b1;
        if ( grp &&  is_end) ded_end_ev[ch]   = 1'b1;
        tick();
        norm_half_ev = '0; norm_end_ev = '0; ded_half_ev = '0; ded_end_ev = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); check("R6", "pending after reset", v, 32'h0);
        rd(1'b1, v); check("R5", "enable after reset", v, 32'h0);
        check("R6", "irq after reset", {31'b0, irq_out}, 32'h0);
        check("R6", "eot_valid after reset", {31'b0, eot_valid}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        pulse(1'b0, 3, 1'b0);
        rd(1'b0, v); check("R1", "normal half ch3", v, 32'h0000_0040);
        wr(1'b0, 32'hFFFF_FFFF);
        pulse(1'b1, 5, 1'b1);
        rd(1'b0, v); check("R1", "dedicated end ch5", v, 32'h0800_0000);
        pulse(1'b0, 7, 1'b1);
        rd(1'b0, v); check("R1", "normal end ch7 added", v, 32'h0800_8000);
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); check("R3", "all ones clears", v, 32'h0);
    endtask

    task automatic t_sticky_irq();
        logic [31:0] v;
        pulse(1'b0, 0, 1'b1);
        tick(); tick();
        rd(1'b0, v); check("R2", "sticky while masked", v, 32'h0000_0002);
        check("R7", "irq masked", {31'b0, irq_out}, 32'h0);
        wr(1'b1, 32'h0000_0001);
        check("R7", "irq with other bit enabled", {31'b0, irq_out}, 32'h0);
        wr(1'b1, 32'h0000_0002);
        rd(1'b1, v); check("R9", "enable readback", v, 32'h0000_0002);
        check("R7", "irq enabled", {31'b0, irq_out}, 32'h1);
        wr(1'b0, 32'h0000_0002);
        check("R7", "irq after clear", {31'b0, irq_out}, 32'h0);
        wr(1'b1, 32'h0);
    endtask

    task automatic t_partial_clear();
        logic [31:0] v;
        pulse(1'b0, 1, 1'b0);
        pulse(1'b0, 2, 1'b1);
        pulse(1'b1, 0, 1'b0);
        pulse(1'b1, 6, 1'b1);
        rd(1'b0, v); check("R1", "four events", v, 32'h2001_0024);
        wr(1'b0, 32'h0001_0020);
        rd(1'b0, v); check("R3", "partial clear", v, 32'h2000_0004);
        rd(1'b0, v);
        wr(1'b0, v);
        rd(1'b0, v); check("R3", "write back read value", v, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        pulse(1'b0, 4, 1'b1);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'hFFFF_FFFF;
        norm_end_ev[4] = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; norm_end_ev = '0;
        rd(1'b0, v); check("R4", "set wins over clear", v, 32'h0000_0200);
        wr(1'b0, 32'hFFFF_FFFF);
    endtask

    task automatic t_helper();
        logic [31:0] v;
        wr(1'b1, 32'hAAAA_AAAA);
        pulse(1'b1, 2, 1'b1);
        pulse(1'b0, 6, 1'b1);
        check("R8", "valid", {31'b0, eot_valid}, 32'h1);
        check("R8", "group normal", {31'b0, eot_dedicated}, 32'h0);
        check("R8", "chan 6", {29'b0, eot_chan}, 32'h6);
        wr(1'b0, 32'h0000_2000);
        check("R8", "group dedicated", {31'b0, eot_dedicated}, 32'h1);
        check("R8", "chan 2", {29'b0, eot_chan}, 32'h2);
        wr(1'b1, 32'h5555_5555);
        check("R8", "end bit masked", {31'b0, eot_valid}, 32'h0);
        rd(1'b0, v); check("R2", "pending kept while masked", v, 32'h0020_0000);
        wr(1'b0, 32'hFFFF_FFFF);
        wr(1'b1, 32'hFFFF_FFFF);
        pulse(1'b0, 0, 1'b0);
        check("R8", "half bit ignored", {31'b0, eot_valid}, 32'h0);
        check("R7", "half bit raises irq", {31'b0, irq_out}, 32'h1);
        wr(1'b0, 32'hFFFF_FFFF);
        wr(1'b1, 32'h0);
    endtask

    task automatic t_reset_mid();
        logic [31:0] v;
        wr(1'b1, 32'hFFFF_FFFF);
        pulse(1'b1, 7, 1'b1);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        rd(1'b0, v); check("R6", "pending cleared by reset", v, 32'h0);
        rd(1'b1, v); check("R5", "enable cleared by reset", v, 32'h0);
        check("R6", "irq low after reset", {31'b0, irq_out}, 32'h0);
    endtask

    initial begin
        fork
            begin
                #1;
                tick(); tick(); tick();
                rst_n = 1'b1;
                tick();
                t_reset();
                t_map();
                t_sticky_irq();
                t_partial_clear();
                t_collision();
                t_helper();
                t_reset_mid();
            end
            begin
                #20000;
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule